// File: doc/BRIEF.md
# Two-Way Tag Lookup with Check-Coded Tags

This block does the tag compare and victim selection for a two-way set-associative instruction cache. Each tag entry holds the tag, a valid flag and a SECDED check field. On a fetch, the surrounding logic reads both tag words of the indexed set from the tag memory and presents them to the block. In the same cycle the block checks each word's code and compares the tags. It reports whether the fetch hit and in which way. On a miss it reports the way to refill.

A way whose tag word fails its code check can never hit. The refill logic takes that way as the victim, so the damaged entry is replaced with a freshly encoded word. Such events are invisible to the fetching side, apart from a saturating counter and a one-cycle event flag. An error in one way is ignored when the other way hits.

When no error is present, a one-bit-per-set least-recently-used indicator picks the victim. When a refill completes, the block produces the encoded tag word and the write command for the tag memory.

Top module: `tag_lookup2w`

## Requirements
- R1: During a request (`req_vld`=1), a way hits only when its word has bit TAG_W (valid) set, bits [TAG_W-1:0] equal `req_tag`, and its code check passes. `hit` is the OR of the two ways. `hit_way` names the hitting way, and is 0 when both ways hit.
- R2: On a request where no way hits and neither word has a code error, `victim_way` equals the set's LRU bit. Every LRU bit is 0 after reset.
- R3: A hit in way w, or a refill of way w, sets that set's LRU bit to the other way from the next cycle onward. When a hit and a refill update the same set in the same cycle, the refill's value is kept.
- R4: On a missing request where a way's word fails its code check, `victim_way` names the failing way. When both ways fail, it names way 0.
- R5: A request that misses while at least one way fails its check raises `err_evt` in that cycle. The same request adds one to `err_count` from the next cycle.
- R6: When one way hits, a code error in the other way is suppressed: `err_evt` stays 0 and `err_count` does not change.
- R7: `err_count` holds at 2^CNT_W-1 once it reaches it. `err_clr`=1 sets it to 0 in the next cycle, taking priority over an increment in the same cycle.
- R8: `fill_vld`=1 drives `wr_en`=1 in the same cycle, with `wr_way`=`fill_way`, `wr_index`=`fill_index` and `wr_word` laid out as follows: [TAG_W-1:0]=`fill_tag`, [TAG_W]=1 (valid), the Hamming check bits above that, and an overall even-parity bit at the MSB. Every single-bit and every double-bit change to such a word makes its way fail the check.
- R9: With `req_vld`=0, `hit` and `err_evt` are 0, and neither the LRU bits nor `err_count` change because of the tag words presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_vld | input | 1 | Fetch lookup request in this cycle |
| req_index | input | IDX_W | Set index of the fetch |
| req_tag | input | TAG_W | Tag of the fetch address |
| rd_word0 | input | WORD_W | Tag word of way 0 read for `req_index` |
| rd_word1 | input | WORD_W | Tag word of way 1 read for `req_index` |
| hit | output | 1 | Fetch hit |
| hit_way | output | 1 | Way that hit |
| victim_way | output | 1 | Way to refill on a miss |
| err_evt | output | 1 | Counted tag error in this cycle |
| fill_vld | input | 1 | Refill complete strobe |
| fill_index | input | IDX_W | Set being refilled |
| fill_way | input | 1 | Way being refilled |
| fill_tag | input | TAG_W | Tag of the refilled line |
| wr_en | output | 1 | Tag memory write enable |
| wr_way | output | 1 | Way written |
| wr_index | output | IDX_W | Set written |
| wr_word | output | WORD_W | Encoded tag word to write |
| err_clr | input | 1 | Synchronous clear of the error counter |
| err_count | output | CNT_W | Saturating count of handled tag errors |

## Verification
The assertions assume that the two tag words belong to the set named by `req_index` and arrive in the same cycle as the request. They also assume that a damaged word differs from a valid codeword in at most two bits, because larger corruptions can alias into valid codewords. The bench acts as the tag memory: it stores only words taken from `wr_word`, returns them for the requested set, and injects damage by XORing one-bit or two-bit masks onto them. Its expected results come from its own record of which entries it damaged, never from decoding the words.

// File: rtl/tl2_pkg.sv
package tl2_pkg;

    // number of Hamming check bits needed for d data bits
    function automatic int ecc_p(input int d);
        int p;
        p = 1;
        while ((1 << p) < d + p + 1) p++;
        return p;
    endfunction

    // codeword position of the j-th data bit (skips powers of two)
    function automatic int data_pos(input int j);
        int pos;
        int n;
        pos = 2;
        n   = -1;
        while (n < j) begin
            pos++;
            if ((pos & (pos - 1)) != 0) n++;
        end
        return pos;
    endfunction

    typedef struct packed {
        logic err;
        logic hit;
    } way_stat_t;

endpackage

// File: rtl/tl2_ecc_enc.sv
module tl2_ecc_enc #(
    parameter int D = 13,
    parameter int P = 5
) (
    input  logic [D-1:0] data,
    output logic [P-1:0] chk
);
    import tl2_pkg::*;

    for (genvar i = 0; i < P; i++) begin : g_bit
        logic [D-1:0] sel;
        for (genvar j = 0; j < D; j++) begin : g_dat
            if (((data_pos(j) >> i) & 1) != 0) begin : g_on
                assign sel[j] = data[j];
            end else begin : g_off
                assign sel[j] = 1'b0;
            end
        end
        assign chk[i] = ^sel;
    end

endmodule

// File: rtl/tl2_ecc_chk.sv
module tl2_ecc_chk #(
    parameter int D = 13,
    parameter int P = 5,
    localparam int W = D + P + 1
) (
    input  logic [W-1:0] word,
    output logic         err
);
    logic [P-1:0] recomp;
    logic [P-1:0] syndrome;

    tl2_ecc_enc #(.D(D), .P(P)) u_enc (
        .data (word[D-1:0]),
        .chk  (recomp)
    );

    assign syndrome = recomp ^ word[D+P-1:D];
    // any nonzero syndrome or odd overall parity is a detected error
    assign err = (|syndrome) | (^word);

endmodule

// File: rtl/tl2_repl.sv
module tl2_repl #(
    parameter int IDX_W = 3,
    localparam int SETS = 1 << IDX_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] look_idx,
    input  logic             err0,
    input  logic             err1,
    input  logic             hit_upd,
    input  logic             hit_way,
    input  logic             fill_vld,
    input  logic [IDX_W-1:0] fill_idx,
    input  logic             fill_way,
    output logic             victim
);
    logic [SETS-1:0] lru;

    always_ff @(posedge clk) begin
        if (rst) begin
            lru <= '0;
        end else begin
            if (hit_upd)  lru[look_idx] <= ~hit_way;
            if (fill_vld) lru[fill_idx] <= ~fill_way;
        end
    end

    always_comb begin
        if (err0)      victim = 1'b0;
        else if (err1) victim = 1'b1;
        else           victim = lru[look_idx];
    end

    // R3: a refill points the set's next victim at the other way
    a_r3_fill_lru: assert property (@(posedge clk) disable iff (rst)
        fill_vld |=> lru[$past(fill_idx)] == ~$past(fill_way));

endmodule

// File: rtl/tl2_err_cnt.sv
module tl2_err_cnt #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc,
    input  logic             clr,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] TOP = '1;

    always_ff @(posedge clk) begin
        if (rst || clr)                count <= '0;
        else if (inc && count != TOP)  count <= count + 1'b1;
    end

    // R5: one step per counted event below the ceiling
    a_r5_step: assert property (@(posedge clk) disable iff (rst)
        (inc && !clr && count != TOP) |=> count == $past(count) + 1'b1);
    // R7: ceiling holds
    a_r7_sat: assert property (@(posedge clk) disable iff (rst)
        (count == TOP && !clr) |=> count == TOP);
    // R7: clear wins
    a_r7_clr: assert property (@(posedge clk) disable iff (rst)
        clr |=> count == '0);

endmodule

// File: rtl/tag_lookup2w.sv
module tag_lookup2w #(
    parameter int TAG_W = 12,
    parameter int IDX_W = 3,
    parameter int CNT_W = 4,
    localparam int D      = TAG_W + 1,
    localparam int P      = tl2_pkg::ecc_p(D),
    localparam int WORD_W = D + P + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_vld,
    input  logic [IDX_W-1:0]  req_index,
    input  logic [TAG_W-1:0]  req_tag,
    input  logic [WORD_W-1:0] rd_word0,
    input  logic [WORD_W-1:0] rd_word1,
    output logic              hit,
    output logic              hit_way,
    output logic              victim_way,
    output logic              err_evt,
    input  logic              fill_vld,
    input  logic [IDX_W-1:0]  fill_index,
    input  logic              fill_way,
    input  logic [TAG_W-1:0]  fill_tag,
    output logic              wr_en,
    output logic              wr_way,
    output logic [IDX_W-1:0]  wr_index,
    output logic [WORD_W-1:0] wr_word,
    input  logic              err_clr,
    output logic [CNT_W-1:0]  err_count
);
    import tl2_pkg::*;

    logic [WORD_W-1:0] rword [2];
    way_stat_t         st    [2];
    logic              any_hit;
    logic              any_err;

    assign rword[0] = rd_word0;
    assign rword[1] = rd_word1;

    for (genvar w = 0; w < 2; w++) begin : g_way
        tl2_ecc_chk #(.D(D), .P(P)) u_chk (
            .word (rword[w]),
            .err  (st[w].err)
        );
        assign st[w].hit = rword[w][TAG_W] && (rword[w][TAG_W-1:0] == req_tag)
                           && !st[w].err;
    end

    assign any_hit = st[0].hit | st[1].hit;
    assign any_err = st[0].err | st[1].err;
    assign hit     = req_vld & any_hit;
    assign hit_way = ~st[0].hit & st[1].hit;
    assign err_evt = req_vld & ~any_hit & any_err;

    tl2_repl #(.IDX_W(IDX_W)) u_repl (
        .clk      (clk),
        .rst      (rst),
        .look_idx (req_index),
        .err0     (st[0].err),
        .err1     (st[1].err),
        .hit_upd  (hit),
        .hit_way  (hit_way),
        .fill_vld (fill_vld),
        .fill_idx (fill_index),
        .fill_way (fill_way),
        .victim   (victim_way)
    );

    tl2_err_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .inc   (err_evt),
        .clr   (err_clr),
        .count (err_count)
    );

    // refill write path: encode {valid, tag}
    logic [D-1:0] fill_data;
    logic [P-1:0] fill_chk;
    assign fill_data = {1'b1, fill_tag};

    tl2_ecc_enc #(.D(D), .P(P)) u_enc (
        .data (fill_data),
        .chk  (fill_chk)
    );

    assign wr_en    = fill_vld;
    assign wr_way   = fill_way;
    assign wr_index = fill_index;
    assign wr_word  = {^{fill_chk, fill_data}, fill_chk, fill_data};

    // R1: the reported way never carries a code error
    a_r1_clean_hit: assert property (@(posedge clk) disable iff (rst)
        hit |-> !(hit_way ? st[1].err : st[0].err));
    // R4: a failing way is the victim, way 0 first
    a_r4_err0_victim: assert property (@(posedge clk) disable iff (rst)
        (req_vld && !hit && st[0].err) |-> victim_way == 1'b0);
    a_r4_err1_victim: assert property (@(posedge clk) disable iff (rst)
        (req_vld && !hit && !st[0].err && st[1].err) |-> victim_way == 1'b1);
    // R6: a hit leaves the counter alone
    a_r6_masked: assert property (@(posedge clk) disable iff (rst)
        (hit && !err_clr) |=> $stable(err_count));
    // R9: no request, no counting
    a_r9_idle: assert property (@(posedge clk) disable iff (rst)
        (!req_vld && !err_clr) |=> $stable(err_count));

endmodule

// File: tb/tag_lookup2w_tb.sv
module tag_lookup2w_tb;
    localparam int TAG_W  = 12;
    localparam int IDX_W  = 3;
    localparam int CNT_W  = 4;
    localparam int SETS   = 1 << IDX_W;
    localparam int D      = TAG_W + 1;
    localparam int P      = tl2_pkg::ecc_p(D);
    localparam int WORD_W = D + P + 1;
    localparam int MAXC   = (1 << CNT_W) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_vld = 0, fill_vld = 0, fill_way = 0, err_clr = 0;
    logic [IDX_W-1:0]  req_index = '0, fill_index = '0;
    logic [TAG_W-1:0]  req_tag = '0, fill_tag = '0;
    logic [WORD_W-1:0] rd_word0 = '0, rd_word1 = '0;
    logic hit, hit_way, victim_way, err_evt, wr_en, wr_way;
    logic [IDX_W-1:0]  wr_index;
    logic [WORD_W-1:0] wr_word;
    logic [CNT_W-1:0]  err_count;

    always #10 clk = ~clk;

    tag_lookup2w #(.TAG_W(TAG_W), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst(rst), .req_vld(req_vld), .req_index(req_index),
        .req_tag(req_tag), .rd_word0(rd_word0), .rd_word1(rd_word1),
        .hit(hit), .hit_way(hit_way), .victim_way(victim_way), .err_evt(err_evt),
        .fill_vld(fill_vld), .fill_index(fill_index), .fill_way(fill_way),
        .fill_tag(fill_tag), .wr_en(wr_en), .wr_way(wr_way), .wr_index(wr_index),
        .wr_word(wr_word), .err_clr(err_clr), .err_count(err_count)
    );

    // bench-side tag memory and reference state
    logic [WORD_W-1:0] mem  [SETS][2];
    logic [WORD_W-1:0] dmg  [SETS][2];
    logic [TAG_W-1:0]  mtag [SETS][2];
    bit                mval [SETS][2];
    bit                mlru [SETS];
    int                mcnt;
    int                total = 0;
    int                bad   = 0;

    task automatic check(input bit ok, input string r, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d t=%0t", r, act, exp, $time);
        end
    endtask

    task automatic run(input bit rq, input int idx, input logic [TAG_W-1:0] tg,
                       input bit fv, input int fidx, input bit fw,
                       input logic [TAG_W-1:0] ftg, input bit clr);
        bit e0, e1, h0, h1, xhit, xway, xvic, xevt;
        logic [WORD_W-1:0] cap;
        req_vld = rq; req_index = IDX_W'(idx); req_tag = tg;
        rd_word0 = mem[idx][0] ^ dmg[idx][0];
        rd_word1 = mem[idx][1] ^ dmg[idx][1];
        fill_vld = fv; fill_index = IDX_W'(fidx); fill_way = fw; fill_tag = ftg;
        err_clr = clr;
        @(negedge clk);
        e0 = dmg[idx][0] != '0;
        e1 = dmg[idx][1] != '0;
        h0 = mval[idx][0] && mtag[idx][0] == tg && !e0;
        h1 = mval[idx][1] && mtag[idx][1] == tg && !e1;
        xhit = rq && (h0 || h1);
        xway = h0 ? 1'b0 : 1'b1;
        xevt = rq && !(h0 || h1) && (e0 || e1);
        xvic = e0 ? 1'b0 : (e1 ? 1'b1 : mlru[idx]);
        check(hit == xhit, rq ? "R1 hit" : "R9 hit idle", int'(hit), int'(xhit));
        if (xhit) check(hit_way == xway, "R1 hit_way", int'(hit_way), int'(xway));
        if (rq && !xhit)
            check(victim_way == xvic, (e0 || e1) ? "R4 victim" : "R2 victim",
                  int'(victim_way), int'(xvic));
        check(err_evt == xevt, (rq && (h0 || h1)) ? "R6 err_evt" : "R5 err_evt",
              int'(err_evt), int'(xevt));
        check(int'(err_count) == mcnt, "R7 err_count", int'(err_count), mcnt);
        check(wr_en == fv, "R8 wr_en", int'(wr_en), int'(fv));
        cap = wr_word;
        if (fv) begin
            check(wr_way == fw && int'(wr_index) == fidx, "R8 wr target",
                  int'(wr_index), fidx);
            check(cap[TAG_W-1:0] == ftg && cap[TAG_W] && !(^cap), "R8 wr_word layout",
                  int'(cap[TAG_W-1:0]), int'(ftg));
        end
        @(posedge clk);
        if (xhit) mlru[idx] = ~xway;
        if (fv) begin
            mlru[fidx] = ~fw;
            mem[fidx][fw] = cap; dmg[fidx][fw] = '0;
            mtag[fidx][fw] = ftg; mval[fidx][fw] = 1;
        end
        if (clr) mcnt = 0;
        else if (xevt && mcnt < MAXC) mcnt++;
        #1;
    endtask

    task automatic look(input int idx, input logic [TAG_W-1:0] tg);
        run(1, idx, tg, 0, 0, 0, '0, 0);
    endtask

    task automatic fill(input int idx, input bit w, input logic [TAG_W-1:0] tg);
        run(0, 0, '0, 1, idx, w, tg, 0);
    endtask

    initial begin
        #(20 * 150000);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int s = 0; s < SETS; s++) begin
            mlru[s] = 0;
            for (int w = 0; w < 2; w++) begin
                mem[s][w] = '0; dmg[s][w] = '0; mtag[s][w] = '0; mval[s][w] = 0;
            end
        end
        mcnt = 0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // reset state
        @(negedge clk);
        check(err_count == '0, "R7 reset count", int'(err_count), 0);
        check(hit == 1'b0 && err_evt == 1'b0, "R9 reset idle", int'(hit), 0);
        @(posedge clk); #1;
        // R1: empty set, tag 0 in an invalid word must miss; R2 victim way 0
        look(5, 12'h000);
        // refills and hits (R3, R8)
        fill(2, 0, 12'hA5A);
        fill(2, 1, 12'h3C3);
        look(2, 12'hA5A);
        look(2, 12'h3C3);
        look(2, 12'h111);
        look(2, 12'hA5A);
        look(2, 12'h111);
        // R9: matching tag with no request leaves LRU and count untouched
        run(0, 2, 12'h3C3, 0, 0, 0, '0, 0);
        look(2, 12'h777);
        // R3: hit and refill on the same set in one cycle, refill wins
        run(1, 2, 12'hA5A, 1, 2, 0, 12'hA5A, 0);
        look(2, 12'h777);
        // R6: way 1 damaged, way 0 hits -> masked
        dmg[2][1] = WORD_W'(1) << 0;
        look(2, 12'hA5A);
        // R4, R5: miss with way 1 damaged
        look(2, 12'h3C3);
        // R4: both damaged -> way 0, double-bit damage
        dmg[2][0] = WORD_W'(3) << 3;
        look(2, 12'h3C3);
        // R8: every single-bit change is caught
        fill(3, 0, 12'h5A5);
        fill(3, 1, 12'h0F0);
        for (int b = 0; b < WORD_W; b++) begin
            dmg[3][0] = WORD_W'(1) << b;
            look(3, 12'h5A5);
        end
        // R7: count has saturated; clear together with an event
        dmg[3][0] = WORD_W'(1) << 2;
        run(1, 3, 12'h5A5, 0, 0, 0, '0, 1);
        look(3, 12'h5A5);
        // R8: double-bit changes in way 1
        dmg[3][0] = '0;
        for (int b = 0; b + 1 < WORD_W; b += 2) begin
            dmg[3][1] = WORD_W'(3) << b;
            look(3, 12'h0F0);
        end
        dmg[3][1] = (WORD_W'(1) << (WORD_W - 1)) | WORD_W'(1);
        look(3, 12'h0F0);
        // refill repairs damaged way; then clean hit
        fill(3, 1, 12'h0F0);
        look(3, 12'h0F0);
        run(0, 0, '0, 0, 0, 0, '0, 1);
        run(0, 0, '0, 0, 0, 0, '0, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule